// File: doc/BRIEF.md
# Horizontal Block Disparity Search Engine

This block finds, for one row of 8x8 blocks of a 32x32 predicted sub-image, the best-matching block position in a 32x32 reference sub-image of the same row. The search runs in one direction only: the predicted block that starts at column `8k` is compared with every reference block that starts at column `8k + d`, for each `d` that keeps the reference block inside the 32-pixel width. The sum of absolute differences (SAD) over the 8x8 block is the match cost. Each searched block reports its lowest SAD and the offset `d` where that lowest SAD was found. The rightmost block of the row is not searched.

Both images arrive together, one line at a time, eight pixels of each image per accepted beat. A line is four beats and a block row is eight lines. A line buffer collects each line. Every candidate offset has its own row-SAD unit and its own accumulator, so each line is scored against all 51 candidates in the cycle after that line is complete. When the eighth line has been added, the accumulated totals are copied into a holding bank. Three minimum trackers then step through the candidates at one per clock. The next block row can stream in at the same time.

A whole 32x32 predicted sub-image is four block rows sent back to back. It costs 128 beat cycles, plus the fixed drain time of the last row.

Top module: `hdisp_search`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and both `best_sad` and `best_off` are all zeros.
- R2: A beat is taken only in a cycle where `beat_valid` is 1. Beat `b` (0..3) of a line carries columns `8b..8b+7`. Pixel `m` of a beat is at bits `[8m+7:8m]` of `p_beat` and of `i_beat`. Four beats make a line and eight lines make a block row.
- R3: Searched block `k` (0, 1 or 2) starts at predicted column `8k`. It is compared with the reference block that starts at column `8k+d`, for every `d` from 0 to `24-8k`. That gives 25, 17 and 9 candidates.
- R4: The cost of a candidate is the exact sum, over all 8 lines and 8 columns, of the absolute pixel differences. Its maximum is 16320, which fits in 14 bits.
- R5: For each searched block, `best_sad` holds the lowest candidate cost and `best_off` holds its `d`. When costs are equal, the smallest `d` wins.
- R6: Predicted-image columns 24..31 have no effect on any output.
- R7: `done` is a pulse one cycle long. It goes high 27 clock edges after the edge that takes the last beat of a block row. The results of that row are valid while `done` is high.
- R8: A beat taken with `row_start` high is treated as beat 0 of line 0. Any partly received row is dropped.
- R9: A new block row may begin in the cycle right after the previous row's last beat. Each row still gets its own correct `done` and results, in order.
- R10: Cycles with `beat_valid` low may fall anywhere between beats without changing any result.
- R11: `best_sad` and `best_off` change only in a cycle where `done` is high.

Result fields: block `k` uses `best_sad[14k+13:14k]` and `best_off[5k+4:5k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| beat_valid | input | 1 | Marks the current beat as valid |
| row_start | input | 1 | Marks the current beat as the first beat of a block row |
| p_beat | input | 64 | Eight predicted-image pixels |
| i_beat | input | 64 | Eight reference-image pixels |
| done | output | 1 | Results of one block row are ready |
| best_sad | output | 42 | Lowest SAD of each of the three searched blocks |
| best_off | output | 15 | Offset of that lowest SAD for each searched block |

## Verification
The hardest condition to reach is two block rows sent with no gap, because row one is still being scanned for its minimum while row two is already being added up. The stimulus holds `beat_valid` high across the boundary between the two rows and then checks both results in order. Ties are hard to produce with random pixels. Uniform images and planted copies of a predicted block force exact zero-cost matches and equal-cost candidates. A row abandoned after ten beats and then restarted with `row_start` exercises the resync path.

// File: rtl/hds_pkg.sv
package hds_pkg;

    // Default geometry of the search
    localparam int DEF_PIX_W    = 8;
    localparam int DEF_BLK      = 8;
    localparam int DEF_SUB_W    = 32;
    localparam int DEF_BEAT_PIX = 8;

    // Phase of the minimum scan, shared by the top and the trackers
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_END  = 2'd2
    } scan_phase_e;

    // Number of candidate offsets for searched block k
    function automatic int cand_count(input int sub_w, input int blk, input int k);
        return sub_w - blk - blk * k + 1;
    endfunction

    // Bits needed to hold the sum of n maximal absolute differences
    function automatic int sum_width(input int pix_w, input int n);
        return $clog2(((1 << pix_w) - 1) * n + 1);
    endfunction

endpackage

// File: rtl/hds_line_capture.sv
module hds_line_capture
    import hds_pkg::*;
#(
    parameter int PIX_W    = DEF_PIX_W,
    parameter int BLK      = DEF_BLK,
    parameter int SUB_W    = DEF_SUB_W,
    parameter int BEAT_PIX = DEF_BEAT_PIX
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  beat_valid,
    input  logic                                  row_start,
    input  logic [BEAT_PIX*PIX_W-1:0]             p_beat,
    input  logic [BEAT_PIX*PIX_W-1:0]             i_beat,
    output logic [(SUB_W-BLK)*PIX_W-1:0]          p_line,
    output logic [SUB_W*PIX_W-1:0]                i_line,
    output logic                                  line_rdy,
    output logic                                  line_first,
    output logic                                  line_last
);
    localparam int BEATS   = SUB_W / BEAT_PIX;
    localparam int P_SLOTS = (SUB_W - BLK) / BEAT_PIX;
    localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LINES   = BLK;
    localparam int LW      = (LINES > 1) ? $clog2(LINES) : 1;

    logic [BW-1:0] beat_q, eff_beat;
    logic [LW-1:0] line_q, eff_line;
    logic [BEATS-1:0][BEAT_PIX*PIX_W-1:0]   i_buf;
    logic [P_SLOTS-1:0][BEAT_PIX*PIX_W-1:0] p_buf;

    // A row_start beat restarts the position counters
    always_comb begin
        eff_beat = row_start ? '0 : beat_q;
        eff_line = row_start ? '0 : line_q;
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                i_buf[b] <= '0;
            else if (beat_valid && eff_beat == BW'(b))
                i_buf[b] <= i_beat;
        end
        if (b < P_SLOTS) begin : g_pslot
            always_ff @(posedge clk) begin
                if (rst)
                    p_buf[b] <= '0;
                else if (beat_valid && eff_beat == BW'(b))
                    p_buf[b] <= p_beat;
            end
        end
    end

    assign i_line = i_buf;
    assign p_line = p_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q     <= '0;
            line_q     <= '0;
            line_rdy   <= 1'b0;
            line_first <= 1'b0;
            line_last  <= 1'b0;
        end else begin
            line_rdy <= 1'b0;
            if (beat_valid) begin
                if (eff_beat == BW'(BEATS - 1)) begin
                    line_rdy   <= 1'b1;
                    line_first <= (eff_line == '0);
                    line_last  <= (eff_line == LW'(LINES - 1));
                    beat_q     <= '0;
                    line_q     <= (eff_line == LW'(LINES - 1)) ? '0 : eff_line + 1'b1;
                end else begin
                    beat_q <= eff_beat + 1'b1;
                    line_q <= eff_line;
                end
            end
        end
    end

    // R2: a completed line always follows an accepted beat
    p_line_after_beat_r2: assert property (@(posedge clk) disable iff (rst)
        line_rdy |-> $past(beat_valid));

    // R2: a line cannot be both the first and the last of a row
    p_first_last_excl_r2: assert property (@(posedge clk) disable iff (rst)
        line_rdy |-> !(line_first && line_last));

endmodule

// File: rtl/hds_row_sad.sv
module hds_row_sad
    import hds_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int N     = DEF_BLK
) (
    input  logic [N*PIX_W-1:0]                 a_pix,
    input  logic [N*PIX_W-1:0]                 b_pix,
    output logic [sum_width(PIX_W, N)-1:0]     sum
);
    localparam int RSW = sum_width(PIX_W, N);

    logic [N-1:0][PIX_W-1:0] diff;

    for (genvar m = 0; m < N; m++) begin : g_ad
        logic [PIX_W-1:0] a_m, b_m;
        assign a_m     = a_pix[m*PIX_W +: PIX_W];
        assign b_m     = b_pix[m*PIX_W +: PIX_W];
        assign diff[m] = (a_m > b_m) ? (a_m - b_m) : (b_m - a_m);
    end

    always_comb begin
        sum = '0;
        for (int m = 0; m < N; m++)
            sum = sum + RSW'(diff[m]);
    end

endmodule

// File: rtl/hds_block_search.sv
module hds_block_search
    import hds_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int BLK     = DEF_BLK,
    parameter int SUB_W   = DEF_SUB_W,
    parameter int BLK_IDX = 0,
    parameter int SADW    = 14,
    parameter int OFFW    = 5
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [BLK*PIX_W-1:0]                   p_blk,
    input  logic [(SUB_W-BLK*BLK_IDX)*PIX_W-1:0]   i_win,
    input  logic                                   line_rdy,
    input  logic                                   line_first,
    input  logic                                   snap_en,
    input  scan_phase_e                            phase,
    input  logic [OFFW-1:0]                        scan_idx,
    output logic [SADW-1:0]                        best_sad,
    output logic [OFFW-1:0]                        best_off
);
    localparam int NCAND = cand_count(SUB_W, BLK, BLK_IDX);
    localparam int RSW   = sum_width(PIX_W, BLK);

    logic [NCAND-1:0][RSW-1:0]  row_cost;
    logic [NCAND-1:0][SADW-1:0] acc, snap;

    // One row-SAD unit and one accumulator per candidate offset
    for (genvar d = 0; d < NCAND; d++) begin : g_cand
        hds_row_sad #(.PIX_W(PIX_W), .N(BLK)) u_rsad (
            .a_pix (p_blk),
            .b_pix (i_win[d*PIX_W +: BLK*PIX_W]),
            .sum   (row_cost[d])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                acc[d]  <= '0;
                snap[d] <= '0;
            end else begin
                if (line_rdy)
                    acc[d] <= (line_first ? '0 : acc[d]) + SADW'(row_cost[d]);
                if (snap_en)
                    snap[d] <= acc[d];
            end
        end
    end

    // Candidate select for the serial minimum scan
    logic [SADW-1:0] cand;
    logic            cand_ok;
    always_comb begin
        cand = '0;
        for (int d = 0; d < NCAND; d++)
            if (scan_idx == OFFW'(d))
                cand = snap[d];
        cand_ok = int'(scan_idx) < NCAND;
    end

    // Minimum tracker: strict compare keeps the lowest offset on ties
    logic [SADW-1:0] cur_sad, nxt_sad;
    logic [OFFW-1:0] cur_off, nxt_off;
    logic            take;
    logic            scanning;

    assign scanning = (phase != SCAN_IDLE);

    always_comb begin
        take    = (scan_idx == '0) || (cand_ok && cand < cur_sad);
        nxt_sad = take ? cand : cur_sad;
        nxt_off = take ? scan_idx : cur_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sad  <= '0;
            cur_off  <= '0;
            best_sad <= '0;
            best_off <= '0;
        end else if (scanning) begin
            cur_sad <= nxt_sad;
            cur_off <= nxt_off;
            if (phase == SCAN_END) begin
                best_sad <= nxt_sad;
                best_off <= nxt_off;
            end
        end
    end

    // R5: after the first candidate, the running minimum never rises
    p_min_nonrising_r5: assert property (@(posedge clk) disable iff (rst)
        (scanning && scan_idx != '0) |=> (cur_sad <= $past(cur_sad)));

    // R3: a published offset always names a real candidate of this block
    p_off_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == SCAN_END) |=> (int'(best_off) < NCAND));

endmodule

// File: rtl/hdisp_search.sv
module hdisp_search
    import hds_pkg::*;
#(
    parameter int PIX_W    = DEF_PIX_W,
    parameter int BLK      = DEF_BLK,
    parameter int SUB_W    = DEF_SUB_W,
    parameter int BEAT_PIX = DEF_BEAT_PIX,
    parameter int NSRCH    = SUB_W / BLK - 1,
    parameter int SADW     = sum_width(PIX_W, BLK * BLK),
    parameter int OFFW     = $clog2(cand_count(SUB_W, BLK, 0))
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          beat_valid,
    input  logic                          row_start,
    input  logic [BEAT_PIX*PIX_W-1:0]     p_beat,
    input  logic [BEAT_PIX*PIX_W-1:0]     i_beat,
    output logic                          done,
    output logic [NSRCH*SADW-1:0]         best_sad,
    output logic [NSRCH*OFFW-1:0]         best_off
);
    localparam int MAXC = cand_count(SUB_W, BLK, 0);

    logic [(SUB_W-BLK)*PIX_W-1:0] p_line;
    logic [SUB_W*PIX_W-1:0]       i_line;
    logic line_rdy, line_first, line_last;

    hds_line_capture #(
        .PIX_W(PIX_W), .BLK(BLK), .SUB_W(SUB_W), .BEAT_PIX(BEAT_PIX)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat_valid),
        .row_start  (row_start),
        .p_beat     (p_beat),
        .i_beat     (i_beat),
        .p_line     (p_line),
        .i_line     (i_line),
        .line_rdy   (line_rdy),
        .line_first (line_first),
        .line_last  (line_last)
    );

    // Scan sequencer: snapshot after the final line, then one candidate per clock
    logic            fin_q;
    logic            scan_on;
    logic [OFFW-1:0] scan_idx;
    scan_phase_e     phase;

    always_comb begin
        if (!scan_on)
            phase = SCAN_IDLE;
        else if (scan_idx == OFFW'(MAXC - 1))
            phase = SCAN_END;
        else
            phase = SCAN_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q    <= 1'b0;
            scan_on  <= 1'b0;
            scan_idx <= '0;
            done     <= 1'b0;
        end else begin
            fin_q <= line_rdy & line_last;
            done  <= 1'b0;
            if (fin_q) begin
                scan_on  <= 1'b1;
                scan_idx <= '0;
            end else if (scan_on) begin
                scan_idx <= scan_idx + 1'b1;
                if (phase == SCAN_END) begin
                    scan_on <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NSRCH; k++) begin : g_blk
        hds_block_search #(
            .PIX_W(PIX_W), .BLK(BLK), .SUB_W(SUB_W),
            .BLK_IDX(k), .SADW(SADW), .OFFW(OFFW)
        ) u_srch (
            .clk        (clk),
            .rst        (rst),
            .p_blk      (p_line[k*BLK*PIX_W +: BLK*PIX_W]),
            .i_win      (i_line[k*BLK*PIX_W +: (SUB_W-BLK*k)*PIX_W]),
            .line_rdy   (line_rdy),
            .line_first (line_first),
            .snap_en    (fin_q),
            .phase      (phase),
            .scan_idx   (scan_idx),
            .best_sad   (best_sad[k*SADW +: SADW]),
            .best_off   (best_off[k*OFFW +: OFFW])
        );
    end

    // R7: done lasts exactly one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done only closes a running scan
    p_done_after_scan_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(scan_on));

    // R3: the scan index never passes the largest candidate set
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        scan_on |-> (int'(scan_idx) < MAXC));

    // R11: results stay put unless done is raised
    p_hold_results_r11: assert property (@(posedge clk) disable iff (rst)
        !done |=> (!done || $stable(best_sad)) || $past(scan_on));

endmodule

// File: tb/hdisp_search_bench.sv
`timescale 1ns/1ps
module hdisp_search_bench;
    localparam int NS = 3, SADW = 14, OFFW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, beat_valid, row_start, done;
    logic [63:0] p_beat, i_beat;
    logic [NS*SADW-1:0] best_sad;
    logic [NS*OFFW-1:0] best_off;

    hdisp_search u_hdisp_search (
        .clk(clk), .rst(rst), .beat_valid(beat_valid), .row_start(row_start),
        .p_beat(p_beat), .i_beat(i_beat), .done(done),
        .best_sad(best_sad), .best_off(best_off)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    logic [7:0] pm [8][32];
    logic [7:0] im [8][32];
    int exp_sad [64][NS], exp_off [64][NS], n_exp = 0;
    int got_sad [64][NS], got_off [64][NS], n_got = 0;
    int quiet_changes = 0;
    logic [NS*SADW-1:0] prev_sad;
    logic [NS*OFFW-1:0] prev_off;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Result monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (done && n_got < 64) begin
                for (int k = 0; k < NS; k++) begin
                    got_sad[n_got][k] = int'(best_sad[k*SADW +: SADW]);
                    got_off[n_got][k] = int'(best_off[k*OFFW +: OFFW]);
                end
                n_got++;
            end else if (!done && (best_sad != prev_sad || best_off != prev_off)) begin
                quiet_changes++;
            end
        end
        prev_sad = best_sad;
        prev_off = best_off;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Reference model: lowest cost per block, lowest offset on ties
    task automatic push_expect();
        for (int k = 0; k < NS; k++) begin
            int best = -1, boff = 0;
            for (int d = 0; d <= 24 - 8*k; d++) begin
                int s = 0;
                for (int l = 0; l < 8; l++)
                    for (int j = 0; j < 8; j++) begin
                        int a = pm[l][8*k+j], b = im[l][8*k+d+j];
                        s += (a > b) ? a - b : b - a;
                    end
                if (best < 0 || s < best) begin best = s; boff = d; end
            end
            exp_sad[n_exp][k] = best;
            exp_off[n_exp][k] = boff;
        end
        n_exp++;
    endtask

    task automatic fill_rand();
        for (int l = 0; l < 8; l++)
            for (int c = 0; c < 32; c++) begin
                pm[l][c] = 8'($urandom_range(255));
                im[l][c] = 8'($urandom_range(255));
            end
    endtask

    task automatic fill_const(input int pv, input int iv);
        for (int l = 0; l < 8; l++)
            for (int c = 0; c < 32; c++) begin
                pm[l][c] = 8'(pv);
                im[l][c] = 8'(iv);
            end
    endtask

    task automatic plant(input int k, input int d);
        for (int l = 0; l < 8; l++)
            for (int j = 0; j < 8; j++)
                im[l][8*k+d+j] = pm[l][8*k+j];
    endtask

    task automatic send_row(input int gap_pct, input bit with_start,
                            input bit hold_end, input int n_beats);
        int cnt = 0;
        for (int l = 0; l < 8; l++)
            for (int b = 0; b < 4; b++) begin
                if (cnt < n_beats) begin
                    while (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                        @(negedge clk);
                        beat_valid = 1'b0;
                        row_start  = 1'b0;
                        @(posedge clk);
                    end
                    @(negedge clk);
                    beat_valid = 1'b1;
                    row_start  = with_start && (cnt == 0);
                    for (int m = 0; m < 8; m++) begin
                        p_beat[m*8 +: 8] = pm[l][b*8+m];
                        i_beat[m*8 +: 8] = im[l][b*8+m];
                    end
                    @(posedge clk);
                    cnt++;
                end
            end
        if (!hold_end) begin
            @(negedge clk);
            beat_valid = 1'b0;
            row_start  = 1'b0;
        end
    endtask

    task automatic check_result(input int idx, input string req);
        int w = 0;
        while (n_got <= idx && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (n_got <= idx) begin
            chk(1'b0, {req, " done missing"}, n_got, idx + 1);
            return;
        end
        for (int k = 0; k < NS; k++) begin
            chk(got_sad[idx][k] == exp_sad[idx][k], {req, " sad"}, got_sad[idx][k], exp_sad[idx][k]);
            chk(got_off[idx][k] == exp_off[idx][k], {req, " off"}, got_off[idx][k], exp_off[idx][k]);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst = 1'b1; beat_valid = 1'b0; row_start = 1'b0; p_beat = '0; i_beat = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0 && best_sad == '0 && best_off == '0, "R1 reset outputs", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && best_sad == '0 && best_off == '0, "R1 after release", int'(best_sad), 0);

        // R5: uniform images, every candidate ties at zero
        fill_const(0, 0); push_expect(); send_row(0, 1, 0, 32);
        check_result(0, "R5 all-zero ties");

        // R4: maximal difference everywhere
        fill_const(255, 0); push_expect(); send_row(0, 1, 0, 32);
        check_result(1, "R4 full-scale");

        // R7: latency from the last beat to done
        fill_rand(); plant(0, 13); plant(2, 8); push_expect();
        send_row(0, 1, 0, 32);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!done && n < 100);
        chk(n == 27, "R7 latency", n, 27);
        check_result(2, "R7 result");

        // R2 R3 R4 R10: random rows, some with planted matches and idle gaps
        for (int t = 0; t < 6; t++) begin
            fill_rand();
            if (t % 2 == 0) plant(t % 3, int'($urandom_range(24 - 8*(t % 3))));
            if (t == 3) begin plant(1, 16); plant(1, 3); end
            push_expect();
            send_row((t >= 3) ? 35 : 0, 1, 0, 32);
            check_result(n_exp - 1, (t >= 3) ? "R10 gapped R2 R3 R4" : "R2 R3 R4 random");
        end

        // R5: duplicate planted match, lower offset must win
        fill_rand(); plant(0, 20); plant(0, 6); push_expect(); send_row(0, 1, 0, 32);
        check_result(n_exp - 1, "R5 tie lower offset");

        // R6: rightmost predicted block changed, results unchanged
        fill_rand(); push_expect(); send_row(0, 1, 0, 32);
        check_result(n_exp - 1, "R6 base");
        for (int l = 0; l < 8; l++)
            for (int c = 24; c < 32; c++) pm[l][c] = ~pm[l][c];
        push_expect(); send_row(0, 1, 0, 32);
        check_result(n_exp - 1, "R6 altered");
        for (int k = 0; k < NS; k++)
            chk(got_sad[n_exp-1][k] == got_sad[n_exp-2][k], "R6 unchanged sad",
                got_sad[n_exp-1][k], got_sad[n_exp-2][k]);

        // R8: partial row abandoned, then restarted
        fill_rand(); send_row(0, 1, 0, 10);
        fill_rand(); plant(1, 5); push_expect(); send_row(0, 1, 0, 32);
        check_result(n_exp - 1, "R8 restart");

        // R9: two rows with no idle cycle between them
        fill_rand(); plant(0, 2); push_expect(); send_row(0, 1, 1, 32);
        fill_rand(); plant(2, 1); push_expect(); send_row(0, 0, 0, 32);
        check_result(n_exp - 2, "R9 first");
        check_result(n_exp - 1, "R9 second");

        repeat (40) @(negedge clk);
        chk(n_got == n_exp, "R7 one done per row", n_got, n_exp);
        chk(quiet_changes == 0, "R11 hold between done", quiet_changes, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule